// File: doc/BRIEF.md
# Dual-Port Byte-Lane Synchronous RAM

This block is a true dual-port static memory with two fully independent ports, each running on its own clock. Either port can read or write any word at any time, and both may address the same word at once. Each port registers its address, write data, read/write direction, a pair of opposite-polarity chip enables and two active-low byte-lane selects on the rising edge of its clock. Every write is byte-masked.

Read data leaves each port on a unidirectional bus with one valid flag per byte lane. A lane whose flag is low carries zeros, which stands in for a released tristate lane. A per-port mode pin picks the read latency. In flow-through mode the data follows the capturing edge. In pipelined mode it arrives one edge later, and after a deselect the port needs two consecutive selected edges before it drives again. An asynchronous output enable blanks the lanes at once. It has no effect on storage or on the pipeline.

Storage is written from two clock domains without any array having two drivers. Each port owns a bank, and per-lane tag bits record which bank holds the latest copy. The default depth is kept small. It is set through `ADDR_W`, and a value of 14 gives the full 16K-word organisation.

Top module: `dpbl_ram`

## Requirements
- R1: A port counts as selected at an edge only when its `ce0_n` is 0 and its `ce1` is 1. At any edge where the port is not selected, nothing is written, and after that edge every lane flag of the port is 0.
- R2: Lane 1 (`lane_n[1]`) covers data bits 15:8 and lane 0 (`lane_n[0]`) covers bits 7:0. A lane takes part in a read or a write only while its select bit is 0.
- R3: At an edge where the port is selected with `rnw` = 0, only the enabled lanes of the addressed word take the write data. The other lanes keep their stored bytes.
- R4: With `pipe` = 0, a selected read with `rnw` = 1 at edge n shows the stored word on the enabled lanes from edge n until edge n+1, with those lane flags at 1.
- R5: With `pipe` = 1, the same read appears one edge later, from edge n+1 until edge n+2. A lane is shown only if the port was selected at both edge n and edge n+1. After a deselect, the port therefore needs two consecutive selected edges before it drives again.
- R6: While `oe_n` is 1, every lane flag and all data bits of the port are 0, with no clock edge needed. Releasing `oe_n` brings back the data held in the output registers unchanged.
- R7: In flow-through mode, after an edge that registers a write, or an edge that leaves a lane unselected, that lane's flag is 0 and its data bits are 0.
- R8: A word written on one port at edge n can be read on the other port at any of its edges after n. A read of the same word registered at the same instant as the write returns the word stored before that write.
- R9: While a port's reset is low, all of its lane flags and output data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A asynchronous reset, active low |
| a_ce0_n | input | 1 | Port A chip enable, active low |
| a_ce1 | input | 1 | Port A chip enable, active high |
| a_rnw | input | 1 | Port A direction: 1 read, 0 write |
| a_lane_n | input | LANES | Port A byte-lane selects, active low |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_pipe | input | 1 | Port A latency mode: 0 flow-through, 1 pipelined |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, zero on lanes not shown |
| a_rvalid | output | LANES | Port A per-lane output valid |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B asynchronous reset, active low |
| b_ce0_n | input | 1 | Port B chip enable, active low |
| b_ce1 | input | 1 | Port B chip enable, active high |
| b_rnw | input | 1 | Port B direction: 1 read, 0 write |
| b_lane_n | input | LANES | Port B byte-lane selects, active low |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_pipe | input | 1 | Port B latency mode: 0 flow-through, 1 pipelined |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, zero on lanes not shown |
| b_rvalid | output | LANES | Port B per-lane output valid |

## Verification
The bench model treats a stimulus applied before edge n in three ways. A flow-through result is due right after edge n, and a pipelined result right after edge n+1, gated by the select seen at n+1. An output-enable change is due within the same cycle, with no edge at all. A write at edge n is visible to the other port's read registered at n+1, while a read registered at n still returns the old word. Inputs change only just after a falling edge. Both ports are compared at every falling edge, midway between the edges, and the output-enable case adds extra checks taken a nanosecond after the pin moves, all before the next rising edge.

// File: rtl/dpbl_pkg.sv
`timescale 1ns/1ps
package dpbl_pkg;

  typedef enum logic {
    OUT_FLOW = 1'b0,
    OUT_PIPE = 1'b1
  } out_mode_e;

  // A port is live only for the one enable pairing
  function automatic logic port_sel(input logic ce0_n, input logic ce1);
    return !ce0_n && ce1;
  endfunction

endpackage

// File: rtl/dpbl_store.sv
`timescale 1ns/1ps
module dpbl_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              a_clk,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [LANES-1:0]  a_wen,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rword,
  input  logic              b_clk,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [LANES-1:0]  b_wen,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rword
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / LANES;

  // One bank per writing port; tag_a ^ tag_b = 1 means bank A is newest
  logic [DATA_W-1:0] bank_a [DEPTH];
  logic [DATA_W-1:0] bank_b [DEPTH];
  logic [LANES-1:0]  tag_a  [DEPTH];
  logic [LANES-1:0]  tag_b  [DEPTH];

  function automatic logic [DATA_W-1:0] merge(input logic [LANES-1:0] own_a,
                                              input logic [DATA_W-1:0] wa,
                                              input logic [DATA_W-1:0] wb);
    logic [DATA_W-1:0] res;
    res = '0;
    for (int l = 0; l < LANES; l++)
      res[l*LANE_W +: LANE_W] = own_a[l] ? wa[l*LANE_W +: LANE_W] : wb[l*LANE_W +: LANE_W];
    return res;
  endfunction

  logic [LANES-1:0] a_owner, b_owner;
  assign a_owner = tag_a[a_addr] ^ tag_b[a_addr];
  assign b_owner = tag_a[b_addr] ^ tag_b[b_addr];

  // Read-before-write: a same-edge collision returns the old word
  always_ff @(posedge a_clk) begin
    a_rword <= merge(a_owner, bank_a[a_addr], bank_b[a_addr]);
    for (int l = 0; l < LANES; l++) begin
      if (a_wen[l]) begin
        bank_a[a_addr][l*LANE_W +: LANE_W] <= a_wdata[l*LANE_W +: LANE_W];
        tag_a[a_addr][l] <= ~tag_b[a_addr][l];
      end
    end
  end

  always_ff @(posedge b_clk) begin
    b_rword <= merge(b_owner, bank_a[b_addr], bank_b[b_addr]);
    for (int l = 0; l < LANES; l++) begin
      if (b_wen[l]) begin
        bank_b[b_addr][l*LANE_W +: LANE_W] <= b_wdata[l*LANE_W +: LANE_W];
        tag_b[b_addr][l] <= tag_a[b_addr][l];
      end
    end
  end

endmodule

// File: rtl/dpbl_port.sv
`timescale 1ns/1ps
module dpbl_port #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce0_n,
  input  logic              ce1,
  input  logic              rnw,
  input  logic [LANES-1:0]  lane_n,
  input  logic              oe_n,
  input  logic              pipe,
  input  logic [DATA_W-1:0] rword,
  output logic              sel,
  output logic [LANES-1:0]  wen,
  output logic [DATA_W-1:0] rdata,
  output logic [LANES-1:0]  rvalid
);
  localparam int LANE_W = DATA_W / LANES;

  logic [LANES-1:0]  ft_v, pp_v, lane_on, rd_lanes;
  logic [DATA_W-1:0] pp_d, src_d;

  assign sel      = dpbl_pkg::port_sel(ce0_n, ce1);
  assign wen      = {LANES{sel & ~rnw}} & ~lane_n;
  assign rd_lanes = {LANES{sel & rnw}} & ~lane_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ft_v <= '0;
      pp_v <= '0;
      pp_d <= '0;
    end else begin
      ft_v <= rd_lanes;
      pp_v <= ft_v & {LANES{sel}};
      pp_d <= rword;
    end
  end

  assign lane_on = ((pipe == dpbl_pkg::OUT_PIPE) ? pp_v : ft_v) & {LANES{~oe_n}};
  assign src_d   = (pipe == dpbl_pkg::OUT_PIPE) ? pp_d : rword;
  assign rvalid  = lane_on;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rdata[g*LANE_W +: LANE_W] = lane_on[g] ? src_d[g*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/dpbl_ram.sv
`timescale 1ns/1ps
module dpbl_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              a_clk,
  input  logic              a_rst_n,
  input  logic              a_ce0_n,
  input  logic              a_ce1,
  input  logic              a_rnw,
  input  logic [LANES-1:0]  a_lane_n,
  input  logic              a_oe_n,
  input  logic              a_pipe,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic [LANES-1:0]  a_rvalid,
  input  logic              b_clk,
  input  logic              b_rst_n,
  input  logic              b_ce0_n,
  input  logic              b_ce1,
  input  logic              b_rnw,
  input  logic [LANES-1:0]  b_lane_n,
  input  logic              b_oe_n,
  input  logic              b_pipe,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic [LANES-1:0]  b_rvalid
);
  logic              a_sel, b_sel;
  logic [LANES-1:0]  a_wen, b_wen;
  logic [DATA_W-1:0] a_rword, b_rword;

  dpbl_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_store (
    .a_clk(a_clk), .a_addr(a_addr), .a_wen(a_wen), .a_wdata(a_wdata), .a_rword(a_rword),
    .b_clk(b_clk), .b_addr(b_addr), .b_wen(b_wen), .b_wdata(b_wdata), .b_rword(b_rword)
  );

  dpbl_port #(.DATA_W(DATA_W), .LANES(LANES)) u_port_a (
    .clk(a_clk), .rst_n(a_rst_n), .ce0_n(a_ce0_n), .ce1(a_ce1), .rnw(a_rnw),
    .lane_n(a_lane_n), .oe_n(a_oe_n), .pipe(a_pipe), .rword(a_rword),
    .sel(a_sel), .wen(a_wen), .rdata(a_rdata), .rvalid(a_rvalid)
  );

  dpbl_port #(.DATA_W(DATA_W), .LANES(LANES)) u_port_b (
    .clk(b_clk), .rst_n(b_rst_n), .ce0_n(b_ce0_n), .ce1(b_ce1), .rnw(b_rnw),
    .lane_n(b_lane_n), .oe_n(b_oe_n), .pipe(b_pipe), .rword(b_rword),
    .sel(b_sel), .wen(b_wen), .rdata(b_rdata), .rvalid(b_rvalid)
  );

endmodule

// File: rtl/dpbl_port_chk.sv
`timescale 1ns/1ps
module dpbl_port_chk #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce0_n,
  input logic              ce1,
  input logic              rnw,
  input logic [LANES-1:0]  lane_n,
  input logic              oe_n,
  input logic              pipe,
  input logic [LANES-1:0]  wen,
  input logic [DATA_W-1:0] rdata,
  input logic [LANES-1:0]  rvalid
);
  logic live;
  assign live = !ce0_n && ce1;

  // R1: an unselected port writes nothing
  p_unsel_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> wen == '0);

  // R1: an unselected edge blanks every lane after it
  p_unsel_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> rvalid == '0);

  // R5: pipelined output stays off one more edge after a deselect
  p_pipe_reactivate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> ##1 (!pipe || rvalid == '0));

  // R6: output enable high blanks flags and data
  p_oe_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (rvalid == '0 && rdata == '0));

  // R7: a flow-through write edge leaves the lanes quiet
  p_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && live && !rnw) |=> (pipe || rvalid == '0));

  // R2: a raised upper select keeps the upper lane off in flow-through mode
  p_upper_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && lane_n[LANES-1]) |=> (pipe || !rvalid[LANES-1]));

endmodule

bind dpbl_ram dpbl_port_chk #(.DATA_W(DATA_W), .LANES(LANES)) i_chk_a (
  .clk(a_clk), .rst_n(a_rst_n), .ce0_n(a_ce0_n), .ce1(a_ce1), .rnw(a_rnw),
  .lane_n(a_lane_n), .oe_n(a_oe_n), .pipe(a_pipe), .wen(a_wen),
  .rdata(a_rdata), .rvalid(a_rvalid)
);

bind dpbl_ram dpbl_port_chk #(.DATA_W(DATA_W), .LANES(LANES)) i_chk_b (
  .clk(b_clk), .rst_n(b_rst_n), .ce0_n(b_ce0_n), .ce1(b_ce1), .rnw(b_rnw),
  .lane_n(b_lane_n), .oe_n(b_oe_n), .pipe(b_pipe), .wen(b_wen),
  .rdata(b_rdata), .rvalid(b_rvalid)
);

// File: tb/test_dpbl_ram.sv
`timescale 1ns/1ps
module test_dpbl_ram;

  typedef struct packed {
    logic        ce0_n;
    logic        ce1;
    logic        rnw;
    logic [1:0]  lane_n;
    logic        oe_n;
    logic        pipe;
    logic [7:0]  addr;
    logic [15:0] wdata;
  } pin_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  pin_t pa, pb;
  logic [15:0] a_rdata, b_rdata;
  logic [1:0]  a_rvalid, b_rvalid;

  always #4 clk = ~clk;   // 125 MHz

  dpbl_ram i_dpbl_ram (
    .a_clk(clk), .a_rst_n(rst_n), .a_ce0_n(pa.ce0_n), .a_ce1(pa.ce1), .a_rnw(pa.rnw),
    .a_lane_n(pa.lane_n), .a_oe_n(pa.oe_n), .a_pipe(pa.pipe), .a_addr(pa.addr),
    .a_wdata(pa.wdata), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
    .b_clk(clk), .b_rst_n(rst_n), .b_ce0_n(pb.ce0_n), .b_ce1(pb.ce1), .b_rnw(pb.rnw),
    .b_lane_n(pb.lane_n), .b_oe_n(pb.oe_n), .b_pipe(pb.pipe), .b_addr(pb.addr),
    .b_wdata(pb.wdata), .b_rdata(b_rdata), .b_rvalid(b_rvalid)
  );

  // Behavioural reference model
  logic [15:0] mdl [256];
  logic [1:0]  e_ft_v [2];
  logic [1:0]  e_pp_v [2];
  logic [15:0] e_ft_d [2];
  logic [15:0] e_pp_d [2];
  int n_vec = 0;
  int n_bad = 0;
  string cur_req = "R9";

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 16'h0000;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        e_ft_v[p] = 2'b00; e_pp_v[p] = 2'b00; e_ft_d[p] = 16'h0; e_pp_d[p] = 16'h0;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        pin_t q;
        logic on;
        q  = (p == 0) ? pa : pb;
        on = (q.ce0_n == 1'b0) && (q.ce1 == 1'b1);
        e_pp_v[p] = e_ft_v[p] & {on, on};
        e_pp_d[p] = e_ft_d[p];
        e_ft_d[p] = mdl[q.addr];
        e_ft_v[p] = (on && q.rnw) ? ~q.lane_n : 2'b00;
      end
      for (int p = 0; p < 2; p++) begin
        pin_t q;
        q = (p == 0) ? pa : pb;
        if (q.ce0_n == 1'b0 && q.ce1 == 1'b1 && q.rnw == 1'b0) begin
          if (!q.lane_n[0]) mdl[q.addr][7:0]  = q.wdata[7:0];
          if (!q.lane_n[1]) mdl[q.addr][15:8] = q.wdata[15:8];
        end
      end
    end
  end

  task automatic check_port(input int p);
    pin_t q;
    logic [1:0]  v;
    logic [15:0] d, exp_d, got_d;
    logic [1:0]  got_v;
    q = (p == 0) ? pa : pb;
    if (!rst_n) begin
      v = 2'b00; d = 16'h0;
    end else begin
      v = (q.pipe ? e_pp_v[p] : e_ft_v[p]) & {~q.oe_n, ~q.oe_n};
      d = q.pipe ? e_pp_d[p] : e_ft_d[p];
    end
    exp_d = {v[1] ? d[15:8] : 8'h00, v[0] ? d[7:0] : 8'h00};
    got_d = (p == 0) ? a_rdata : b_rdata;
    got_v = (p == 0) ? a_rvalid : b_rvalid;
    n_vec++;
    if (got_v !== v || got_d !== exp_d) begin
      n_bad++;
      $display("FAIL %s port %0d at %0t: got valid=%b data=%h, expected valid=%b data=%h",
               cur_req, p, $time, got_v, got_d, v, exp_d);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    check_port(0);
    check_port(1);
  endtask

  task automatic idle(input int p);
    if (p == 0) begin pa.ce0_n = 1'b1; pa.ce1 = 1'b0; pa.rnw = 1'b1; pa.lane_n = 2'b11; end
    else        begin pb.ce0_n = 1'b1; pb.ce1 = 1'b0; pb.rnw = 1'b1; pb.lane_n = 2'b11; end
  endtask

  task automatic rd(input int p, input logic [7:0] ad, input logic [1:0] ln);
    if (p == 0) begin pa.ce0_n = 1'b0; pa.ce1 = 1'b1; pa.rnw = 1'b1; pa.lane_n = ln; pa.addr = ad; end
    else        begin pb.ce0_n = 1'b0; pb.ce1 = 1'b1; pb.rnw = 1'b1; pb.lane_n = ln; pb.addr = ad; end
  endtask

  task automatic wr(input int p, input logic [7:0] ad, input logic [15:0] dt, input logic [1:0] ln);
    if (p == 0) begin pa.ce0_n = 1'b0; pa.ce1 = 1'b1; pa.rnw = 1'b0; pa.lane_n = ln; pa.addr = ad; pa.wdata = dt; end
    else        begin pb.ce0_n = 1'b0; pb.ce1 = 1'b1; pb.rnw = 1'b0; pb.lane_n = ln; pb.addr = ad; pb.wdata = dt; end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog (all requirements): run did not end, expected completion");
    finish_run();
  end

  initial begin
    pa = '0; pb = '0;
    idle(0); idle(1);
    pa.pipe = 1'b0; pb.pipe = 1'b1;
    // R9: outputs quiet while reset is held
    cur_req = "R9";
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R3: full-word writes from both ports
    cur_req = "R3";
    for (int i = 0; i < 8; i++) begin wr(0, 8'(i), 16'hA500 + 16'(i) * 16'h0111, 2'b00); cyc(); end
    idle(0);
    for (int i = 8; i < 12; i++) begin wr(1, 8'(i), 16'h3C00 + 16'(i), 2'b00); cyc(); end
    idle(1); cyc();

    // R4 (port A flow-through) and R5 (port B pipelined) back-to-back reads
    cur_req = "R4 R5";
    for (int i = 0; i < 12; i++) begin rd(0, 8'(i), 2'b00); rd(1, 8'(11 - i), 2'b00); cyc(); end
    idle(0); idle(1); cyc(); cyc();

    // R3: byte-masked writes, lane bit 1 = bits 15:8
    cur_req = "R3";
    wr(0, 8'd2, 16'h1234, 2'b01); cyc();
    wr(0, 8'd3, 16'h5678, 2'b10); cyc();
    wr(1, 8'd1, 16'hC3C3, 2'b10); cyc();
    idle(1);
    rd(0, 8'd2, 2'b00); cyc();
    rd(0, 8'd3, 2'b00); cyc();
    rd(0, 8'd1, 2'b00); cyc();

    // R2: single-lane reads on both latencies
    cur_req = "R2";
    rd(0, 8'd4, 2'b01); cyc();
    rd(0, 8'd4, 2'b10); cyc();
    rd(1, 8'd5, 2'b10); cyc();
    rd(1, 8'd5, 2'b01); cyc();
    idle(1); cyc(); cyc();

    // R1: every non-selecting enable pairing, then a blocked write
    cur_req = "R1";
    rd(0, 8'd6, 2'b00); pa.ce0_n = 1'b1; pa.ce1 = 1'b1; cyc();
    rd(0, 8'd6, 2'b00); pa.ce0_n = 1'b0; pa.ce1 = 1'b0; cyc();
    rd(0, 8'd6, 2'b00); pa.ce0_n = 1'b1; pa.ce1 = 1'b0; cyc();
    wr(0, 8'd1, 16'hFFFF, 2'b00); pa.ce1 = 1'b0; cyc();
    rd(0, 8'd1, 2'b00); cyc(); cyc();

    // R5: pipelined reactivation after a one-edge deselect
    cur_req = "R5";
    rd(1, 8'd6, 2'b00); cyc(); cyc();
    idle(1); cyc();
    rd(1, 8'd7, 2'b00); cyc(); cyc(); cyc();
    idle(1); cyc();

    // R7: a flow-through write edge and an unselected lane stay quiet
    cur_req = "R7";
    wr(0, 8'd9, 16'h0F0F, 2'b00); cyc();
    rd(0, 8'd9, 2'b10); cyc();
    idle(0); cyc();

    // R6: output enable acts between edges and leaves the data intact
    cur_req = "R6";
    rd(0, 8'd9, 2'b00); cyc();
    idle(0);
    pa.oe_n = 1'b1; #1; check_port(0);
    pa.oe_n = 1'b0; #1; check_port(0);
    rd(1, 8'd9, 2'b00); cyc(); cyc();
    pb.oe_n = 1'b1; #1; check_port(1);
    pb.oe_n = 1'b0; #1; check_port(1);
    idle(1); cyc();

    // R8: same-edge collision returns old word, next edge returns new
    cur_req = "R8";
    pb.pipe = 1'b0;
    wr(0, 8'd5, 16'hBEEF, 2'b00); rd(1, 8'd5, 2'b00); cyc();
    idle(0); cyc();
    wr(1, 8'd2, 16'h7E57, 2'b00); rd(0, 8'd2, 2'b00); cyc();
    idle(1); cyc();
    idle(0); cyc();

    // R4 R5: swapped latency modes
    cur_req = "R4 R5";
    pa.pipe = 1'b1; pb.pipe = 1'b0;
    for (int i = 0; i < 6; i++) begin rd(0, 8'(i), 2'b00); rd(1, 8'(i + 4), 2'b00); cyc(); end
    idle(0); idle(1); cyc(); cyc();

    finish_run();
  end

endmodule